// File: doc/BRIEF.md
# Four-channel DMA status and interrupt flag keeper

This block keeps the per-channel flags of a four-channel DMA controller. The channel engines send it single-cycle event pulses: transaction start, block request, block start, block done, transaction done, error, abort and channel disable. From these pulses it keeps two 8-bit registers that the CPU can read. The interrupt-flag register holds an error flag and a completion flag per channel, and software clears its bits by writing ones. The status register is read-only and holds a busy bit and a pending bit per channel. These two bits clear by themselves on specific channel events.

Each channel also raises one interrupt request. That request is the OR of the channel's two interrupt flags, each gated by its own enable input. The block does not move data, generate addresses or arbitrate. All flag state is registered: an event or a write seen at a rising clock edge shows in the registers after that edge. The interrupt requests follow the flags and enables combinationally.

Top module: `dma_status_flags`

## Requirements
- R1: After an asynchronous reset (rst_ni low), flag_reg_o, status_reg_o and irq_o are all zero.
- R2: flag_reg_o bit 4+n is the error flag of channel n. An error pulse on channel n sets this bit at the next clock edge.
- R3: flag_reg_o bit n is the completion flag of channel n. It is set by a transaction-done pulse. A block-done pulse sets it only when rpt_unlim_i[n] is high; otherwise a block-done pulse leaves it unchanged.
- R4: A write with wr_sel_i = 0 clears every flag_reg_o bit whose wr_data_i bit is one. Bits written with zero keep their value.
- R5: When a set event and a write-one clear hit the same flag bit in the same cycle, the bit ends up set.
- R6: status_reg_o bit 4+n is the busy bit of channel n. A transaction-start pulse sets it.
- R7: A busy bit clears when its channel sees a disable pulse, when its completion flag is set, or when its error flag is set. A clear in the same cycle as a start leaves the bit cleared.
- R8: status_reg_o bit n is the pending bit of channel n. A block-request pulse sets it. A block-start or abort pulse clears it, and a clear wins over a request in the same cycle.
- R9: A write with wr_sel_i = 1, which targets the status register, changes neither register.
- R10: irq_o[n] is high exactly when (error flag n and err_ie_i[n]) or (completion flag n and cmp_ie_i[n]).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trn_start_i | input | 4 | Transaction start pulse, one bit per channel |
| blk_req_i | input | 4 | Block request pulse |
| blk_start_i | input | 4 | Block transfer start pulse |
| blk_done_i | input | 4 | Block transfer done pulse |
| trn_done_i | input | 4 | Transaction done pulse |
| err_i | input | 4 | Error pulse |
| abort_i | input | 4 | Abort pulse |
| disable_i | input | 4 | Channel disable pulse |
| rpt_unlim_i | input | 4 | Unlimited repeat mode, one level per channel |
| err_ie_i | input | 4 | Error interrupt enable |
| cmp_ie_i | input | 4 | Completion interrupt enable |
| wr_en_i | input | 1 | CPU register write strobe |
| wr_sel_i | input | 1 | Write target: 0 selects the flag register, 1 the status register |
| wr_data_i | input | 8 | CPU write data |
| flag_reg_o | output | 8 | Interrupt-flag register |
| status_reg_o | output | 8 | Status register |
| irq_o | output | 4 | Per-channel interrupt request |

## Verification
Three pairs of functions can land on the same flag bit in the same cycle. The first is a hardware set and a software clear of one flag. The second is a transaction start and a busy-clearing event. The third is a block request and a block start. The vector table provokes each pair on purpose: it issues an error pulse together with a write of one to that error bit, a start together with a transaction done, and a request together with a block start. It then compares both registers after that edge with the outcome that R5, R7 and R8 require.

// File: rtl/dma_flag_pkg.sv
package dma_flag_pkg;
  localparam int unsigned NUM_CH  = 4;
  localparam int unsigned REG_W   = 2 * NUM_CH;

  typedef struct packed {
    logic trn_start;
    logic blk_req;
    logic blk_start;
    logic blk_done;
    logic trn_done;
    logic err;
    logic abort;
    logic dis;
  } ch_evt_t;
endpackage

// File: rtl/dma_wr_decode.sv
module dma_wr_decode #(
  parameter int unsigned NCH = 4
) (
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [2*NCH-1:0] wr_data_i,
  output logic [NCH-1:0]   clr_err_o,
  output logic [NCH-1:0]   clr_cmp_o
);
  logic flag_wr;

  // status register target (sel=1) produces no clears
  assign flag_wr   = wr_en_i & ~wr_sel_i;
  assign clr_err_o = flag_wr ? wr_data_i[2*NCH-1:NCH] : '0;
  assign clr_cmp_o = flag_wr ? wr_data_i[NCH-1:0]     : '0;
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_flag_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  ch_evt_t evt_i,
  input  logic    rpt_unlim_i,
  input  logic    clr_err_i,
  input  logic    clr_cmp_i,
  output logic    err_q_o,
  output logic    cmp_q_o,
  output logic    busy_q_o,
  output logic    pend_q_o
);
  logic set_err, set_cmp, busy_clr, pend_clr;
  logic err_d, cmp_d, busy_d, pend_d;

  assign set_err  = evt_i.err;
  assign set_cmp  = evt_i.trn_done | (evt_i.blk_done & rpt_unlim_i);
  assign busy_clr = evt_i.dis | set_cmp | set_err;
  assign pend_clr = evt_i.blk_start | evt_i.abort;

  always_comb begin
    err_d  = set_err | (err_q_o & ~clr_err_i);
    cmp_d  = set_cmp | (cmp_q_o & ~clr_cmp_i);
    busy_d = ~busy_clr & (evt_i.trn_start | busy_q_o);
    pend_d = ~pend_clr & (evt_i.blk_req | pend_q_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q_o  <= 1'b0;
      cmp_q_o  <= 1'b0;
      busy_q_o <= 1'b0;
      pend_q_o <= 1'b0;
    end else begin
      err_q_o  <= err_d;
      cmp_q_o  <= cmp_d;
      busy_q_o <= busy_d;
      pend_q_o <= pend_d;
    end
  end

  a_r2_err_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.err |=> err_q_o);
  a_r3_unlim_block_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.blk_done && rpt_unlim_i) |=> cmp_q_o);
  a_r3_limited_block_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.blk_done && !rpt_unlim_i && !evt_i.trn_done) |=> $stable(cmp_q_o));
  a_r4_clear_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_cmp_i && !evt_i.trn_done && !evt_i.blk_done) |=> !cmp_q_o);
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_err_i && evt_i.err) |=> err_q_o);
  a_r7_busy_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.dis || evt_i.err || evt_i.trn_done) |=> !busy_q_o);
  a_r6_busy_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.trn_start && !evt_i.dis && !evt_i.err && !evt_i.trn_done && !evt_i.blk_done)
    |=> busy_q_o);
  a_r8_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i.blk_start || evt_i.abort) |=> !pend_q_o);
endmodule

// File: rtl/dma_irq_gen.sv
module dma_irq_gen #(
  parameter int unsigned NCH = 4
) (
  input  logic [NCH-1:0] err_flag_i,
  input  logic [NCH-1:0] cmp_flag_i,
  input  logic [NCH-1:0] err_ie_i,
  input  logic [NCH-1:0] cmp_ie_i,
  output logic [NCH-1:0] irq_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_irq
    assign irq_o[g] = (err_flag_i[g] & err_ie_i[g]) | (cmp_flag_i[g] & cmp_ie_i[g]);
  end
endmodule

// File: rtl/dma_status_flags.sv
module dma_status_flags
  import dma_flag_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH-1:0]   trn_start_i,
  input  logic [NUM_CH-1:0]   blk_req_i,
  input  logic [NUM_CH-1:0]   blk_start_i,
  input  logic [NUM_CH-1:0]   blk_done_i,
  input  logic [NUM_CH-1:0]   trn_done_i,
  input  logic [NUM_CH-1:0]   err_i,
  input  logic [NUM_CH-1:0]   abort_i,
  input  logic [NUM_CH-1:0]   disable_i,
  input  logic [NUM_CH-1:0]   rpt_unlim_i,
  input  logic [NUM_CH-1:0]   err_ie_i,
  input  logic [NUM_CH-1:0]   cmp_ie_i,
  input  logic                wr_en_i,
  input  logic                wr_sel_i,
  input  logic [REG_W-1:0]    wr_data_i,
  output logic [REG_W-1:0]    flag_reg_o,
  output logic [REG_W-1:0]    status_reg_o,
  output logic [NUM_CH-1:0]   irq_o
);
  logic [NUM_CH-1:0] clr_err, clr_cmp;
  logic [NUM_CH-1:0] err_q, cmp_q, busy_q, pend_q;

  dma_wr_decode #(.NCH(NUM_CH)) u_wr_decode (
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .clr_err_o (clr_err),
    .clr_cmp_o (clr_cmp)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ch_evt_t evt;
    assign evt = '{trn_start: trn_start_i[g], blk_req: blk_req_i[g],
                   blk_start: blk_start_i[g], blk_done: blk_done_i[g],
                   trn_done: trn_done_i[g], err: err_i[g],
                   abort: abort_i[g], dis: disable_i[g]};

    dma_chan_flags u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .evt_i       (evt),
      .rpt_unlim_i (rpt_unlim_i[g]),
      .clr_err_i   (clr_err[g]),
      .clr_cmp_i   (clr_cmp[g]),
      .err_q_o     (err_q[g]),
      .cmp_q_o     (cmp_q[g]),
      .busy_q_o    (busy_q[g]),
      .pend_q_o    (pend_q[g])
    );
  end

  assign flag_reg_o   = {err_q, cmp_q};
  assign status_reg_o = {busy_q, pend_q};

  dma_irq_gen #(.NCH(NUM_CH)) u_irq (
    .err_flag_i (err_q),
    .cmp_flag_i (cmp_q),
    .err_ie_i   (err_ie_i),
    .cmp_ie_i   (cmp_ie_i),
    .irq_o      (irq_o)
  );

  a_r9_status_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i && trn_start_i == '0 && blk_req_i == '0 && blk_start_i == '0
     && abort_i == '0 && disable_i == '0 && err_i == '0 && trn_done_i == '0
     && blk_done_i == '0) |=> ($stable(status_reg_o) && $stable(flag_reg_o)));
  a_r10_irq_off_when_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_ie_i == '0 && cmp_ie_i == '0) |-> irq_o == '0);
  a_r1_reset_clean: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (flag_reg_o == '0 && status_reg_o == '0));
endmodule

// File: tb/dma_status_flags_bench.sv
module dma_status_flags_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] trn_start, blk_req, blk_start, blk_done, trn_done, err, abort, dis, rpt;
  logic [3:0] err_ie, cmp_ie;
  logic       wr_en, wr_sel;
  logic [7:0] wr_data;
  logic [7:0] flag_reg, status_reg;
  logic [3:0] irq;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dma_status_flags u_dma_status_flags (
    .clk_i(clk), .rst_ni(rst_n),
    .trn_start_i(trn_start), .blk_req_i(blk_req), .blk_start_i(blk_start),
    .blk_done_i(blk_done), .trn_done_i(trn_done), .err_i(err), .abort_i(abort),
    .disable_i(dis), .rpt_unlim_i(rpt), .err_ie_i(err_ie), .cmp_ie_i(cmp_ie),
    .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
    .flag_reg_o(flag_reg), .status_reg_o(status_reg), .irq_o(irq)
  );

  // {trn_start, blk_req, blk_start, blk_done, trn_done, err, abort, dis, rpt,
  //  wr_en, wr_sel, wr_data, exp_flag, exp_status}; nibble bit n = channel n
  localparam int NV = 15;
  localparam logic [61:0] VEC [NV] = '{
    {4'h1,4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,8'h00,8'h00,8'h11}, // R6 R8 set
    {4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,8'h00,8'h00,8'h10}, // R8 block start
    {4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,8'h00,8'h00,8'h10}, // R3 limited block
    {4'h0,4'h0,4'h0,4'h1,4'h0,4'h0,4'h0,4'h0,4'h1,1'b0,1'b0,8'h00,8'h01,8'h00}, // R3 R7 unlimited
    {4'h6,4'hA,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,8'h00,8'h01,8'h6A}, // R6 R8 multi
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h2,4'h0,4'h0,4'h0,1'b0,1'b0,8'h00,8'h21,8'h4A}, // R2 R7 error
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h8,4'h0,4'h0,1'b0,1'b0,8'h00,8'h21,8'h42}, // R8 abort
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h4,4'h0,1'b0,1'b0,8'h00,8'h21,8'h02}, // R7 disable
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,8'h01,8'h20,8'h02}, // R4 clear cmp0
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b1,8'hFF,8'h20,8'h02}, // R9 status write
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h2,4'h0,4'h0,4'h0,1'b1,1'b0,8'h20,8'h20,8'h02}, // R5 set wins
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,8'h20,8'h00,8'h02}, // R4 clear err1
    {4'h8,4'h0,4'h0,4'h0,4'h8,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,8'h00,8'h08,8'h02}, // R7 clear beats start
    {4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,8'h00,8'h08,8'h02}, // R4 zeros keep
    {4'h0,4'h2,4'h2,4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,8'h00,8'h08,8'h00}  // R8 clear beats req
  };

  task automatic idle_inputs();
    {trn_start, blk_req, blk_start, blk_done, trn_done, err, abort, dis, rpt} = '0;
    wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    err_ie = '1; cmp_ie = '1;
    #35;
    check("R1 flag", flag_reg, 8'h00);
    check("R1 status", status_reg, 8'h00);
    check("R1 irq", {4'h0, irq}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {trn_start, blk_req, blk_start, blk_done, trn_done, err, abort, dis, rpt,
       wr_en, wr_sel, wr_data} = VEC[i][61:16];
      @(negedge clk);
      idle_inputs();
      check($sformatf("vec%0d flag", i), flag_reg, VEC[i][15:8]);
      check($sformatf("vec%0d status", i), status_reg, VEC[i][7:0]);
    end
    // R10: completion flag of ch3 is set, no error flags
    cmp_ie = 4'h8; err_ie = 4'h0; #1;
    check("R10 cmp enabled", {4'h0, irq}, 8'h08);
    cmp_ie = 4'h7; err_ie = 4'hF; #1;
    check("R10 cmp masked", {4'h0, irq}, 8'h00);
    @(negedge clk); err = 4'h1;
    @(negedge clk); idle_inputs();
    err_ie = 4'h1; cmp_ie = 4'h0; #1;
    check("R10 err enabled", {4'h0, irq}, 8'h01);
    check("R2 err ch0 flag", flag_reg, 8'h18);
    err_ie = 4'h0; #1;
    check("R10 err masked", {4'h0, irq}, 8'h00);
    // R1: asynchronous reset mid-run
    @(negedge clk); trn_start = 4'hF; blk_req = 4'hF;
    @(negedge clk); idle_inputs();
    check("R6 all busy", status_reg, 8'hFF);
    #3 rst_n = 1'b0; #2;
    check("R1 async flag", flag_reg, 8'h00);
    check("R1 async status", status_reg, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule